// File: doc/BRIEF.md
# Paged Nonvolatile Memory Write Master with Completion Polling

This block is a synchronous master for a byte-wide parallel nonvolatile memory bus. The bus has an active-low chip select, an active-low read strobe, an active-low write strobe, an address bus and a split data bus (output, output enable, input). Bytes are first streamed into a small internal buffer. A start request then names a page length and a base address. The master loads the bytes into the memory as a page, one byte-load cycle per byte. It then finds out when the memory's internal programming has finished by polling the memory with read cycles.

Two polling methods are available, chosen by `poll_mode` when the request starts. In data mode the master keeps reading the last written location until bit 7 matches the bit 7 it wrote. In toggle mode it reads until two reads in a row return the same bit 6. Each request ends with a one-cycle `done` pulse. Flags qualified by `done` report whether the request was rejected or ran into the programming timeout. All bus timings are parameters counted in clock cycles.

The buffer input is a valid/ready stream. A byte is taken on every cycle in which `in_valid` and `in_ready` are both high. `in_ready` is held low while a request is in progress or the buffer is full. The host must therefore keep `in_data` steady until the byte is accepted.

Top module: `pw_master`

## Requirements
- R1: After reset, and at all times while idle, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high, `mem_dq_oe` is low, and `busy` and `done` are low.
- R2: `in_ready` is high only when no request is in progress and the buffer holds fewer than `BUF_DEPTH` bytes. Accepted bytes are written to memory in the order they arrived.
- R3: A start with `page_len` of 0, or with `page_len` larger than the number of buffered bytes, gives `done` with `done_reject` high on the next cycle. It causes no bus activity and leaves the buffer untouched.
- R4: Byte k of a page (k counted from 0) is written to an address whose bits above the page offset equal those of `base_addr`, and whose low log2(`PAGE_BYTES`) bits equal the low bits of `base_addr` plus k, modulo `PAGE_BYTES`.
- R5: In every byte load, `mem_we_n` is low for exactly `WP_CYC` cycles, with chip select low and address and data held. Within a page, consecutive falling edges of `mem_we_n` are exactly 1+`WP_CYC`+`WPH_CYC` cycles apart.
- R6: `mem_dq_oe` is never high while `mem_oe_n` is low. The first poll read starts exactly `POLL_DLY_CYC` cycles after the data driver is released following the last byte load.
- R7: Every poll read has `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high, and addresses the last written location. A read lasts `RD_CYC` cycles, and reads are separated by one cycle with `mem_oe_n` high.
- R8: With `poll_mode`=0 (data mode), the request completes (`done` high, both flags low) on the first read whose bit 7 equals bit 7 of the last byte written.
- R9: With `poll_mode`=1 (toggle mode), the request completes on the first read whose bit 6 equals bit 6 of the read just before it.
- R10: If no completion is seen, `done` rises with `done_timeout` high exactly `TIMEOUT_CYC` cycles after the data driver is released, and all strobes return high.
- R11: A start pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte stream data |
| in_ready | output | 1 | Buffer can accept a byte |
| start | input | 1 | Start a page request (one-cycle pulse) |
| poll_mode | input | 1 | 0 = bit-7 data polling, 1 = bit-6 toggle polling |
| page_len | input | log2(PAGE_BYTES+1) | Number of bytes in the page, 1 to PAGE_BYTES |
| base_addr | input | ADDR_W | Address of the first byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| done_timeout | output | 1 | With done: programming was not seen to finish |
| done_reject | output | 1 | With done: request refused |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_o | output | 8 | Write data |
| mem_dq_oe | output | 1 | Write data driver enable |
| mem_dq_i | input | 8 | Read data from memory |

## Verification
The assertions assume that the parameters are consistent, in particular that one byte load (1+`WP_CYC`+`WPH_CYC` cycles) fits well inside `LOAD_WIN_CYC`. They also assume that `mem_dq_i` matters only during a read cycle. The bench keeps within these assumptions by choosing a load window for its memory model that is longer than a byte load but shorter than the poll delay, so the model is already programming when the first poll read arrives. It then checks addresses, strobe widths, spacing and read placement at the pins, against a model that returns inverted bit 7 and a flipping bit 6 while it is busy.

// File: rtl/pw_pkg.sv
`timescale 1ns/1ps
package pw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_WLOW, S_WHIGH, S_WAIT, S_READ, S_GAP
  } pw_state_t;

  function automatic int pw_max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/pw_byte_fifo.sv
`timescale 1ns/1ps
module pw_byte_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH+1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign dout = store[rp];

  // R2: a byte is only taken when there is room for it
  p_push_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (fill < FW'(DEPTH)));
  // R4: a byte load never consumes from an empty buffer
  p_pop_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (fill != '0));
endmodule

// File: rtl/pw_poll_eval.sv
`timescale 1ns/1ps
module pw_poll_eval (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       stb,
  input  logic       mode,
  input  logic       exp_b7,
  input  logic [7:0] d,
  output logic       hit
);
  logic prev_vld, prev_b6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_vld <= 1'b0;
      prev_b6  <= 1'b0;
    end else if (clr) begin
      prev_vld <= 1'b0;
    end else if (stb) begin
      prev_vld <= 1'b1;
      prev_b6  <= d[6];
    end
  end

  // data mode compares against the written bit 7, toggle mode against the previous read
  assign hit = stb && (mode ? (prev_vld && (prev_b6 == d[6])) : (d[7] == exp_b7));
endmodule

// File: rtl/pw_bus_seq.sv
`timescale 1ns/1ps
module pw_bus_seq
  import pw_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int PG_W         = 8,
  parameter int LEN_W        = 9,
  parameter int FILL_W       = 9,
  parameter int WP_CYC       = 3,
  parameter int WPH_CYC      = 10,
  parameter int LOAD_WIN_CYC = 5000,
  parameter int POLL_DLY_CYC = 5000,
  parameter int RD_CYC       = 4,
  parameter int TIMEOUT_CYC  = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              poll_mode,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] base,
  input  logic [FILL_W-1:0] fill,
  input  logic [7:0]        head,
  output logic              pop,
  input  logic              hit,
  output logic              samp_stb,
  output logic              eval_clr,
  output logic              mode_o,
  output logic              last_b7,
  output logic              busy,
  output logic              done,
  output logic              done_timeout,
  output logic              done_reject,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [7:0]        mem_dq_o,
  output logic              mem_dq_oe
);
  localparam int CNT_W = $clog2(pw_max4(WP_CYC, WPH_CYC, POLL_DLY_CYC, RD_CYC) + 1);
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);
  localparam int GAP_W = $clog2(LOAD_WIN_CYC + 1) + 1;
  localparam int HI_W  = ADDR_W - PG_W;

  pw_state_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [TMO_W-1:0]  tmo;
  logic [LEN_W-1:0]  rem_q;
  logic [PG_W-1:0]   lo_q;
  logic [HI_W-1:0]   page_q;
  logic              tmo_end;

  assign tmo_end  = (tmo == TMO_W'(TIMEOUT_CYC - 1));
  assign busy     = (st != S_IDLE);
  assign pop      = (st == S_SETUP);
  assign samp_stb = (st == S_READ) && (cnt == '0);
  assign eval_clr = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; tmo <= '0; rem_q <= '0; lo_q <= '0; page_q <= '0;
      mode_o <= 1'b0; last_b7 <= 1'b0;
      mem_addr <= '0; mem_ce_n <= 1'b1; mem_oe_n <= 1'b1; mem_we_n <= 1'b1;
      mem_dq_o <= '0; mem_dq_oe <= 1'b0;
      done <= 1'b0; done_timeout <= 1'b0; done_reject <= 1'b0;
    end else begin
      done <= 1'b0; done_timeout <= 1'b0; done_reject <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (len == '0 || int'(len) > int'(fill)) begin
            done <= 1'b1; done_reject <= 1'b1;
          end else begin
            page_q   <= base[ADDR_W-1:PG_W];
            lo_q     <= base[PG_W-1:0];
            rem_q    <= len - 1'b1;
            mode_o   <= poll_mode;
            mem_addr <= base;
            mem_ce_n <= 1'b0;
            st       <= S_SETUP;
          end
        end
        S_SETUP: begin
          mem_we_n  <= 1'b0;
          mem_dq_o  <= head;
          mem_dq_oe <= 1'b1;
          last_b7   <= head[7];
          cnt       <= CNT_W'(WP_CYC - 1);
          st        <= S_WLOW;
        end
        S_WLOW: if (cnt == '0) begin
          mem_we_n <= 1'b1;
          cnt      <= CNT_W'(WPH_CYC - 1);
          st       <= S_WHIGH;
        end else cnt <= cnt - 1'b1;
        S_WHIGH: if (cnt != '0) cnt <= cnt - 1'b1;
        else if (rem_q == '0) begin
          mem_dq_oe <= 1'b0;
          mem_ce_n  <= 1'b1;
          cnt       <= CNT_W'(POLL_DLY_CYC - 1);
          tmo       <= '0;
          st        <= S_WAIT;
        end else begin
          rem_q    <= rem_q - 1'b1;
          lo_q     <= lo_q + 1'b1;
          mem_addr <= {page_q, lo_q + 1'b1};
          st       <= S_SETUP;
        end
        S_WAIT: if (tmo_end) begin
          done <= 1'b1; done_timeout <= 1'b1; st <= S_IDLE;
        end else begin
          tmo <= tmo + 1'b1;
          if (cnt == '0) begin
            mem_ce_n <= 1'b0; mem_oe_n <= 1'b0;
            cnt <= CNT_W'(RD_CYC - 1);
            st  <= S_READ;
          end else cnt <= cnt - 1'b1;
        end
        S_READ: if (samp_stb && hit) begin
          mem_ce_n <= 1'b1; mem_oe_n <= 1'b1; done <= 1'b1; st <= S_IDLE;
        end else if (tmo_end) begin
          mem_ce_n <= 1'b1; mem_oe_n <= 1'b1;
          done <= 1'b1; done_timeout <= 1'b1; st <= S_IDLE;
        end else begin
          tmo <= tmo + 1'b1;
          if (cnt == '0) begin
            mem_oe_n <= 1'b1; st <= S_GAP;
          end else cnt <= cnt - 1'b1;
        end
        S_GAP: if (tmo_end) begin
          mem_ce_n <= 1'b1;
          done <= 1'b1; done_timeout <= 1'b1; st <= S_IDLE;
        end else begin
          tmo <= tmo + 1'b1;
          mem_oe_n <= 1'b0;
          cnt <= CNT_W'(RD_CYC - 1);
          st  <= S_READ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // counters kept only for the timing properties below
  logic [CNT_W:0]   we_run;
  logic [GAP_W-1:0] ld_gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0;
      ld_gap <= '0;
    end else begin
      if (!mem_we_n) we_run <= (we_run == '1) ? we_run : we_run + 1'b1;
      else           we_run <= '0;
      if (st == S_IDLE || !mem_we_n) ld_gap <= '0;
      else if (ld_gap != '1)         ld_gap <= ld_gap + 1'b1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));
  p_page_const_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (mem_addr[ADDR_W-1:PG_W] == page_q));
  p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == (CNT_W+1)'(WP_CYC)));
  p_load_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETUP) |-> (int'(ld_gap) + WP_CYC < LOAD_WIN_CYC));
  p_bus_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);
  p_read_strobes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));
  p_done_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_timeout || done_reject) |-> (done && !(done_timeout && done_reject)));
endmodule

// File: rtl/pw_master.sv
`timescale 1ns/1ps
module pw_master #(
  parameter int ADDR_W       = 17,
  parameter int PAGE_BYTES   = 256,
  parameter int BUF_DEPTH    = 256,
  parameter int WP_CYC       = 3,
  parameter int WPH_CYC      = 10,
  parameter int LOAD_WIN_CYC = 5000,
  parameter int POLL_DLY_CYC = 5000,
  parameter int RD_CYC       = 4,
  parameter int TIMEOUT_CYC  = 250000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [7:0]                        in_data,
  output logic                              in_ready,
  input  logic                              start,
  input  logic                              poll_mode,
  input  logic [$clog2(PAGE_BYTES+1)-1:0]   page_len,
  input  logic [ADDR_W-1:0]                 base_addr,
  output logic                              busy,
  output logic                              done,
  output logic                              done_timeout,
  output logic                              done_reject,
  output logic [ADDR_W-1:0]                 mem_addr,
  output logic                              mem_ce_n,
  output logic                              mem_oe_n,
  output logic                              mem_we_n,
  output logic [7:0]                        mem_dq_o,
  output logic                              mem_dq_oe,
  input  logic [7:0]                        mem_dq_i
);
  localparam int PG_W   = $clog2(PAGE_BYTES);
  localparam int LEN_W  = $clog2(PAGE_BYTES+1);
  localparam int FILL_W = $clog2(BUF_DEPTH+1);

  logic [FILL_W-1:0] fill;
  logic [7:0]        head;
  logic              push, pop, hit, samp_stb, eval_clr, mode_q, last_b7;

  assign in_ready = !busy && (fill < FILL_W'(BUF_DEPTH));
  assign push     = in_valid && in_ready;

  pw_byte_fifo #(.DEPTH(BUF_DEPTH), .W(8)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(push), .din(in_data),
    .pop(pop), .dout(head), .fill(fill)
  );

  pw_poll_eval u_eval (
    .clk(clk), .rst_n(rst_n), .clr(eval_clr), .stb(samp_stb),
    .mode(mode_q), .exp_b7(last_b7), .d(mem_dq_i), .hit(hit)
  );

  pw_bus_seq #(
    .ADDR_W(ADDR_W), .PG_W(PG_W), .LEN_W(LEN_W), .FILL_W(FILL_W),
    .WP_CYC(WP_CYC), .WPH_CYC(WPH_CYC), .LOAD_WIN_CYC(LOAD_WIN_CYC),
    .POLL_DLY_CYC(POLL_DLY_CYC), .RD_CYC(RD_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .poll_mode(poll_mode),
    .len(page_len), .base(base_addr), .fill(fill), .head(head), .pop(pop),
    .hit(hit), .samp_stb(samp_stb), .eval_clr(eval_clr), .mode_o(mode_q),
    .last_b7(last_b7), .busy(busy), .done(done), .done_timeout(done_timeout),
    .done_reject(done_reject), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe)
  );

  // R11: a start seen while busy leaves the running request untouched
  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done));
endmodule

// File: tb/pw_master_tb_top.sv
`timescale 1ns/1ps
module pw_master_tb_top;
  localparam int WP = 3, WPH = 10, PDLY = 60, RD = 4, TMO = 3000;
  localparam int WIN = 40, PROG = 500, DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, start = 1'b0, poll_mode = 1'b0;
  logic [7:0] in_data = '0;
  logic [8:0] page_len = '0;
  logic [16:0] base_addr = '0;
  logic in_ready, busy, done, done_timeout, done_reject;
  logic [16:0] mem_addr;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0] mem_dq_o, mem_dq_i;

  always #10 clk = ~clk;

  pw_master #(.ADDR_W(17), .PAGE_BYTES(256), .BUF_DEPTH(DEPTH), .WP_CYC(WP),
    .WPH_CYC(WPH), .LOAD_WIN_CYC(WIN), .POLL_DLY_CYC(PDLY), .RD_CYC(RD),
    .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .start(start), .poll_mode(poll_mode),
    .page_len(page_len), .base_addr(base_addr), .busy(busy), .done(done),
    .done_timeout(done_timeout), .done_reject(done_reject),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i));

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural memory: page load window, busy programming, status bits
  logic [7:0] mmem [1024];
  logic [16:0] log_a [16];
  logic [7:0] log_d [16];
  int wr_cnt, win, prog;
  logic m_load, m_busy, tog, stuck = 1'b0, pwe, poe;
  logic [7:0] l_data;
  initial for (int i = 0; i < 1024; i++) mmem[i] = 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_load <= 0; m_busy <= 0; tog <= 0; wr_cnt <= 0; win <= 0; prog <= 0;
      pwe <= 1; poe <= 1; l_data <= 0;
    end else begin
      pwe <= mem_we_n; poe <= mem_oe_n;
      if (!mem_ce_n && !pwe && mem_we_n) begin
        mmem[mem_addr[9:0]] <= mem_dq_o;
        log_a[wr_cnt[3:0]] <= mem_addr; log_d[wr_cnt[3:0]] <= mem_dq_o;
        wr_cnt <= wr_cnt + 1; l_data <= mem_dq_o; m_load <= 1; win <= 0;
      end else if (m_load) begin
        if (pwe && !mem_we_n) win <= 0;
        else if (win == WIN) begin m_load <= 0; m_busy <= 1; prog <= 0; end
        else win <= win + 1;
      end
      if (m_busy) begin
        prog <= prog + 1;
        if (prog >= PROG && !stuck) m_busy <= 0;
        if (!poe && mem_oe_n) tog <= ~tog;
      end
    end
  end
  assign mem_dq_i = (!mem_ce_n && !mem_oe_n) ?
    (m_busy ? {~l_data[7], tog, l_data[5:0]} : mmem[mem_addr[9:0]]) : 8'h00;

  // pin monitor, sampled away from the active edge
  int v_r2 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r7 = 0, ce_cnt = 0;
  int last_fall = 0, run = 0, rel_cyc = 0;
  logic p_we = 1, p_dqoe = 0, pg_open = 0, first_rd = 0;
  logic [8:0] pg_bits = '0;
  logic [16:0] last_wa = '0;
  always @(negedge clk) if (rst_n) begin
    if (!mem_we_n && p_we) begin
      if (pg_open) begin
        if (cyc - last_fall != 1 + WP + WPH) v_r5++;
        if (mem_addr[16:8] != pg_bits) v_r4++;
      end else begin pg_open = 1; pg_bits = mem_addr[16:8]; end
      last_fall = cyc; run = 0;
    end
    if (!mem_we_n) begin run++; if (mem_ce_n || !mem_dq_oe) v_r5++; end
    if (mem_we_n && !p_we) begin if (run != WP) v_r5++; last_wa = mem_addr; end
    if (!mem_dq_oe && p_dqoe) begin pg_open = 0; rel_cyc = cyc; first_rd = 1; end
    if (!mem_oe_n) begin
      if (mem_dq_oe) v_r6++;
      if (!mem_we_n || mem_ce_n || mem_addr != last_wa) v_r7++;
      if (first_rd) begin if (cyc - rel_cyc != PDLY) v_r6++; first_rd = 0; end
    end
    if (!mem_ce_n) ce_cnt++;
    if (busy && in_ready) v_r2++;
    p_we = mem_we_n; p_dqoe = mem_dq_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic push1(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = b;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic go(input int len, input logic [16:0] base, input logic mode);
    @(negedge clk);
    start = 1; page_len = 9'(len); base_addr = base; poll_mode = mode;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 strobes idle", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    chk(!busy && !done, "R1 busy/done low", {busy, done}, 0);
    chk(in_ready, "R2 ready after reset", in_ready, 1);
  endtask

  task automatic t_reject_zero;
    int c0;
    c0 = ce_cnt;
    go(0, 17'h00100, 0);
    chk(done && done_reject && !done_timeout, "R3 zero length rejected", {done, done_reject, done_timeout}, 3'b110);
    repeat (5) @(negedge clk);
    chk(ce_cnt == c0 && !busy, "R3 no bus activity", ce_cnt - c0, 0);
  endtask

  task automatic t_short_then_ok;
    bit ok; int w0;
    push1(8'h3C); push1(8'hC5);
    w0 = wr_cnt;
    go(5, 17'h00410, 0);
    chk(done && done_reject, "R3 length above fill rejected", done_reject, 1);
    go(2, 17'h00410, 0);
    wait_done(ok);
    chk(ok && !done_timeout && !done_reject, "R8 data poll completes", {ok, done_timeout, done_reject}, 3'b100);
    chk(!m_busy, "R8 completion only after programming", m_busy, 0);
    chk(wr_cnt - w0 == 2 && log_d[w0[3:0]] == 8'h3C && log_d[(w0 + 1) & 15] == 8'hC5,
        "R3 buffer kept after reject", log_d[(w0 + 1) & 15], 8'hC5);
  endtask

  task automatic t_data_page;
    bit ok; int w0;
    logic [7:0] d [4];
    d[0] = 8'h11; d[1] = 8'hA2; d[2] = 8'h5B; d[3] = 8'h74;
    for (int i = 0; i < 4; i++) push1(d[i]);
    w0 = wr_cnt;
    go(4, 17'h12340, 0);
    chk(busy && !in_ready, "R2 ready low while busy", in_ready, 0);
    wait_done(ok);
    chk(ok && !done_timeout && !m_busy, "R8 data poll with bit7 low", {ok, done_timeout, m_busy}, 3'b100);
    chk(wr_cnt - w0 == 4, "R4 byte count", wr_cnt - w0, 4);
    for (int i = 0; i < 4; i++)
      chk(log_a[(w0 + i) & 15] == 17'h12340 + 17'(i) && log_d[(w0 + i) & 15] == d[i],
          "R4 address/data order", log_a[(w0 + i) & 15], 17'h12340 + 17'(i));
  endtask

  task automatic t_toggle_wrap;
    bit ok; int w0;
    push1(8'h66); push1(8'h99); push1(8'h42);
    w0 = wr_cnt;
    go(3, 17'h0A5FE, 1);
    repeat (5) @(negedge clk);
    go(1, 17'h00000, 0);
    wait_done(ok);
    chk(ok && !done_timeout && !m_busy, "R9 toggle poll completes", {ok, done_timeout, m_busy}, 3'b100);
    chk(log_a[w0 & 15] == 17'h0A5FE && log_a[(w0 + 1) & 15] == 17'h0A5FF && log_a[(w0 + 2) & 15] == 17'h0A500,
        "R4 offset wraps inside page", log_a[(w0 + 2) & 15], 17'h0A500);
    repeat (100) @(negedge clk);
    chk(wr_cnt - w0 == 3 && !busy, "R11 start while busy ignored", wr_cnt - w0, 3);
  endtask

  task automatic t_timeout;
    bit ok;
    stuck = 1;
    push1(8'h81);
    go(1, 17'h00777, 0);
    wait_done(ok);
    chk(ok && done_timeout && !done_reject, "R10 timeout flagged", {ok, done_timeout, done_reject}, 3'b110);
    chk(cyc - rel_cyc == TMO, "R10 timeout distance", cyc - rel_cyc, TMO);
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !busy, "R10 strobes released", {mem_ce_n, mem_oe_n, mem_we_n, busy}, 4'b1110);
    stuck = 0;
    while (m_busy) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_reject_zero();
    t_short_then_ok();
    t_data_page();
    t_toggle_wrap();
    t_timeout();
    chk(v_r2 == 0, "R2 ready/busy overlap", v_r2, 0);
    chk(v_r4 == 0, "R4 page bits moved", v_r4, 0);
    chk(v_r5 == 0, "R5 load timing", v_r5, 0);
    chk(v_r6 == 0, "R6 release and poll delay", v_r6, 0);
    chk(v_r7 == 0, "R7 read cycle form", v_r7, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule